// File: doc/BRIEF.md
# Input-Activity Idle Power Controller

This block decides when a wide programmable logic array may drop into its low-power state. On every clock it compares the array's input bus with the value the bus held one cycle earlier. If automatic power saving is allowed, which is the case while the turbo control bit is low, a run of quiet cycles long enough to cover a programmed idle window raises a low-power request. The first input that changes state drops the request in that same cycle, so the array is awake before it has to act on the new input.

The idle window is given in picoseconds, together with the clock period. The block rounds the window up to a whole number of cycles, so at 100 MHz a 70 ns window becomes 7 cycles. Setting the turbo bit turns automatic saving off and keeps the idle count at zero.

Two clock-enable outputs are also provided, one for the array clock and one for the macrocell clock. Each has its own disable bit and is switched off independently of the other. The reduction of supply current itself happens outside this block.

Top module: `idle_power_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `lp_req` is 0 and both clock enables are 1. Reset clears the stored copy of the bus to all zeros, so a nonzero bus after reset counts as activity in the first cycle. With a zero bus, that first cycle is already a quiet one.
- R2: While `turbo` is 1, `lp_req` is 0 and the idle count is held at zero. This applies in the same cycle that `turbo` rises. Once `turbo` returns to 0 with the bus steady, `lp_req` rises only after a full window has been counted from zero.
- R3: With `turbo` at 0, `lp_req` becomes 1 in the cycle that follows IDLE_CYC consecutive cycles in which the bus equals its value of the previous cycle. IDLE_CYC = ceil(IDLE_WINDOW_PS / CLK_PERIOD_PS).
- R4: A change on any single bus bit, from bit 0 to bit IN_W-1, forces `lp_req` to 0 combinationally. This happens in the same cycle the bus takes its new value.
- R5: A change before the window has elapsed restarts the count, so a further full window of quiet cycles is needed before `lp_req` rises.
- R6: `arr_clk_en` equals the inverse of `arr_clk_off` one cycle later, and `mc_clk_en` equals the inverse of `mc_clk_off` one cycle later. Each enable is independent of the other enable and of `lp_req`.
- R7: Once `lp_req` is 1, it stays 1 for as long as the bus is steady and `turbo` is 0. There is no timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_bus | input | IN_W | Monitored array inputs |
| turbo | input | 1 | 1 disables automatic power saving |
| arr_clk_off | input | 1 | 1 switches the array clock enable off |
| mc_clk_off | input | 1 | 1 switches the macrocell clock enable off |
| lp_req | output | 1 | Low-power request |
| arr_clk_en | output | 1 | Registered enable for the array clock |
| mc_clk_en | output | 1 | Registered enable for the macrocell clock |

## Verification
The hardest case to reach from the ports is a wake caused by a single bit at an arbitrary position on the 61-bit bus while the block is already asleep. It is also hard to tell a count that restarted from one that merely paused. The stimulus therefore brings the block to sleep again before each single-bit flip and walks that flip across every bit position. It also places changes a few cycles into a window and samples one cycle either side of the expected entry. It applies reset once with a nonzero bus and once with a zero bus to show the one-cycle difference that the cleared stored copy makes.

// File: rtl/idle_pwr_pkg.sv
package idle_pwr_pkg;

  // Rounds a time window up to whole clock cycles, with a floor of one.
  function automatic int ceil_div(input int num, input int den);
    int q;
    q = (num + den - 1) / den;
    return (q < 1) ? 1 : q;
  endfunction

  // Index of each clock-enable channel in the packed enable vector
  localparam int CH_ARR = 0;
  localparam int CH_MC  = 1;
  localparam int N_CH   = 2;

endpackage

// File: rtl/ipc_change_detect.sv
module ipc_change_detect #(
  parameter int IN_W    = 61,
  parameter int SLICE_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IN_W-1:0] bus_i,
  output logic            any_change_o
);
  localparam int NSL = (IN_W + SLICE_W - 1) / SLICE_W;

  logic [IN_W-1:0] prev_q;
  logic [IN_W-1:0] diff;
  logic [NSL-1:0]  slice_hit;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= bus_i;
  end

  assign diff = bus_i ^ prev_q;

  // Reduce the difference in slices to keep each OR gate narrow
  for (genvar s = 0; s < NSL; s++) begin : g_slice
    localparam int LO = s * SLICE_W;
    localparam int HI = (LO + SLICE_W > IN_W) ? IN_W - 1 : LO + SLICE_W - 1;
    assign slice_hit[s] = |diff[HI:LO];
  end

  assign any_change_o = |slice_hit;

  AST_CHANGE_MATCHES_BUS: assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> (any_change_o == (bus_i != $past(bus_i)))); // R4

endmodule

// File: rtl/ipc_idle_timer.sv
module ipc_idle_timer #(
  parameter int IDLE_CYC = 7,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_i,
  output logic             armed_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(IDLE_CYC);

  logic [CNT_W-1:0] cnt_q;

  // Saturating count of quiet cycles; any hold request returns it to zero
  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (hold_i)       cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign armed_o = (cnt_q == LIM);
  assign cnt_o   = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt_q <= LIM); // R3
  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst) hold_i |=> (cnt_q == '0)); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst) (!hold_i && cnt_q != LIM) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R3

endmodule

// File: rtl/ipc_clk_gate.sv
module ipc_clk_gate
  import idle_pwr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] off_i,
  output logic [N_CH-1:0] en_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic en_q;

    always_ff @(posedge clk) begin
      if (rst) en_q <= 1'b1;
      else     en_q <= ~off_i[c];
    end

    assign en_o[c] = en_q;

    AST_EN_FOLLOWS_OFF: assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> (en_o[c] == !$past(off_i[c]))); // R6
  end

endmodule

// File: rtl/idle_power_ctrl.sv
module idle_power_ctrl
  import idle_pwr_pkg::*;
#(
  parameter int IN_W           = 61,
  parameter int SLICE_W        = 8,
  parameter int CLK_PERIOD_PS  = 10000,
  parameter int IDLE_WINDOW_PS = 70000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IN_W-1:0] in_bus,
  input  logic            turbo,
  input  logic            arr_clk_off,
  input  logic            mc_clk_off,
  output logic            lp_req,
  output logic            arr_clk_en,
  output logic            mc_clk_en
);
  localparam int IDLE_CYC = ceil_div(IDLE_WINDOW_PS, CLK_PERIOD_PS);
  localparam int CNT_W    = $clog2(IDLE_CYC + 1);

  logic             any_change;
  logic             armed;
  logic [CNT_W-1:0] idle_cnt;
  logic [N_CH-1:0]  off_vec;
  logic [N_CH-1:0]  en_vec;

  ipc_change_detect #(
    .IN_W    (IN_W),
    .SLICE_W (SLICE_W)
  ) u_detect (
    .clk          (clk),
    .rst          (rst),
    .bus_i        (in_bus),
    .any_change_o (any_change)
  );

  ipc_idle_timer #(
    .IDLE_CYC (IDLE_CYC),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .hold_i  (turbo | any_change),
    .armed_o (armed),
    .cnt_o   (idle_cnt)
  );

  // Wake path stays combinational so a toggling input clears the request at once
  assign lp_req = armed & ~any_change & ~turbo;

  assign off_vec[CH_ARR] = arr_clk_off;
  assign off_vec[CH_MC]  = mc_clk_off;

  ipc_clk_gate u_gate (
    .clk   (clk),
    .rst   (rst),
    .off_i (off_vec),
    .en_o  (en_vec)
  );

  assign arr_clk_en = en_vec[CH_ARR];
  assign mc_clk_en  = en_vec[CH_MC];

  AST_WAKE_ON_EDGE: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && in_bus != $past(in_bus)) |-> !lp_req); // R4
  AST_ENTRY_AFTER_QUIET: assert property (@(posedge clk) disable iff (rst) $rose(lp_req) |-> ($stable(in_bus) && $past(idle_cnt) == CNT_W'(IDLE_CYC - 1))); // R3
  AST_TURBO_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst) turbo |=> (idle_cnt == '0)); // R2

endmodule

// File: tb/idle_power_ctrl_bench.sv
`timescale 1ns/1ps
module idle_power_ctrl_bench;
  localparam int IN_W   = 61;
  localparam int PER_PS = 4000;
  localparam int WIN_PS = 70000;
  localparam int N_IDLE = (WIN_PS + PER_PS - 1) / PER_PS;  // 18 cycles

  typedef struct packed {
    logic [63:0] bus;
    logic        trb;
    logic [15:0] hold;
    logic        exp_lp;
  } vec_t;

  // Each row: new bus value and turbo, negedges to wait, expected request
  localparam vec_t VECS [6] = '{
    '{64'h1,                 1'b0, 16'(N_IDLE),     1'b0},
    '{64'h2,                 1'b0, 16'(N_IDLE + 1), 1'b1},
    '{64'h3,                 1'b1, 16'(30),         1'b0},
    '{64'h1000_0000_0000_0000, 1'b0, 16'(N_IDLE + 7), 1'b1},
    '{64'h0F0F,              1'b0, 16'(5),          1'b0},
    '{64'h0F0E,              1'b0, 16'(N_IDLE + 1), 1'b1}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [IN_W-1:0] in_bus = '0;
  logic            turbo = 1'b0;
  logic            arr_clk_off = 1'b0;
  logic            mc_clk_off = 1'b0;
  logic            lp_req, arr_clk_en, mc_clk_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  idle_power_ctrl #(
    .IN_W           (IN_W),
    .SLICE_W        (8),
    .CLK_PERIOD_PS  (PER_PS),
    .IDLE_WINDOW_PS (WIN_PS)
  ) u_idle_power_ctrl (
    .clk         (clk),
    .rst         (rst),
    .in_bus      (in_bus),
    .turbo       (turbo),
    .arr_clk_off (arr_clk_off),
    .mc_clk_off  (mc_clk_off),
    .lp_req      (lp_req),
    .arr_clk_en  (arr_clk_en),
    .mc_clk_en   (mc_clk_en)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state with a nonzero bus
    in_bus = 61'h5A;
    wait_neg(3);
    chk(lp_req, 0, "R1 lp in reset");
    chk(arr_clk_en, 1, "R1 arr en in reset");
    chk(mc_clk_en, 1, "R1 mc en in reset");
    @(negedge clk); rst = 1'b0; #1;
    chk(lp_req, 0, "R1 lp first cycle");
    wait_neg(N_IDLE);
    chk(lp_req, 0, "R1 nonzero bus counts as change");
    wait_neg(1);
    chk(lp_req, 1, "R1 entry after nonzero-bus reset");

    // R3 R4 R2: vector table
    foreach (VECS[k]) begin
      @(negedge clk);
      in_bus = VECS[k].bus[IN_W-1:0];
      turbo  = VECS[k].trb;
      #1;
      chk(lp_req, 0, "R4 wake on apply");
      wait_neg(int'(VECS[k].hold));
      chk(lp_req, VECS[k].exp_lp, "R3 vector result");
    end

    // R2: turbo forces the request low and restarts the count from zero
    @(negedge clk); turbo = 1'b1; #1;
    chk(lp_req, 0, "R2 turbo drops request");
    wait_neg(40);
    chk(lp_req, 0, "R2 held low under turbo");
    @(negedge clk); turbo = 1'b0; #1;
    chk(lp_req, 0, "R2 turbo release");
    wait_neg(N_IDLE - 1);
    chk(lp_req, 0, "R2 window from zero not done");
    wait_neg(1);
    chk(lp_req, 1, "R2 window from zero done");

    // R7: request stays up while quiet
    begin
      bit held = 1'b1;
      for (int i = 0; i < 100; i++) begin
        wait_neg(1);
        if (lp_req !== 1'b1) held = 1'b0;
      end
      chk(held, 1, "R7 request persists");
    end

    // R4: single-bit wake at each position
    for (int b = 0; b < IN_W; b++) begin
      @(negedge clk); in_bus[b] = ~in_bus[b]; #1;
      chk(lp_req, 0, $sformatf("R4 bit %0d wake", b));
      wait_neg(N_IDLE + 1);
      chk(lp_req, 1, $sformatf("R3 re-entry after bit %0d", b));
    end

    // R5: a change mid-window restarts the count
    @(negedge clk); in_bus = 61'h123; #1;
    wait_neg(10);
    chk(lp_req, 0, "R5 mid window");
    @(negedge clk); in_bus = 61'h124; #1;
    chk(lp_req, 0, "R5 second change");
    wait_neg(N_IDLE);
    chk(lp_req, 0, "R5 restarted window not done");
    wait_neg(1);
    chk(lp_req, 1, "R5 restarted window done");

    // R6: independent registered clock enables
    @(negedge clk); arr_clk_off = 1'b1; #1;
    chk(arr_clk_en, 1, "R6 arr en one cycle late");
    wait_neg(1);
    chk(arr_clk_en, 0, "R6 arr en off");
    chk(mc_clk_en, 1, "R6 mc en unaffected");
    chk(lp_req, 1, "R6 request unaffected");
    @(negedge clk); mc_clk_off = 1'b1; arr_clk_off = 1'b0; #1;
    wait_neg(1);
    chk(mc_clk_en, 0, "R6 mc en off");
    chk(arr_clk_en, 1, "R6 arr en back on");
    @(negedge clk); mc_clk_off = 1'b0; #1;
    wait_neg(1);
    chk(mc_clk_en, 1, "R6 mc en back on");

    // R1: reset with a zero bus makes the first cycle quiet
    @(negedge clk); rst = 1'b1; in_bus = '0; #1;
    wait_neg(3);
    chk(lp_req, 0, "R1 lp in second reset");
    @(negedge clk); rst = 1'b0; #1;
    wait_neg(N_IDLE - 1);
    chk(lp_req, 0, "R1 zero bus window not done");
    wait_neg(1);
    chk(lp_req, 1, "R1 zero bus entry one cycle earlier");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule